// File: doc/BRIEF.md
# MMIO Window Decoder and Bridge

This block sits between a host link that issues memory-mapped reads and writes with 64-bit addresses and the register logic of an accelerator. It takes a request only when the upper 32 address bits equal the programmed base. Requests with a different base are dropped without any effect. The lower 32 bits form an offset, and the top offset bit picks one of two windows. The lower half of the offset space is the global window, which is served by a 64-bit register port with group and index fields. The upper half is the per-process window, which is served by a 32-bit AXI4-Lite master. In that window a 9-bit process ID is cut out of the offset and sent on the AXI user sideband.

Only one request is in flight at a time. The block latches the request and decodes it in the next cycle. It then either strobes the register port or runs one AXI4-Lite transaction. It holds a response carrying read data and an error flag until the host takes it, and only then accepts the next request.

Top module: `mmio_window_bridge`

## Requirements
- R1: A request is claimed only when req_addr[63:32] equals bar_base. An unclaimed request produces no response, no register strobe and no AXI transaction, and req_ready returns high two cycles after acceptance.
- R2: For a claimed request, offset bit 31 = 0 selects the global window and offset bit 31 = 1 selects the per-process window. Offset 0x7FFF_FFF8 is global, and offset 0x8000_0000 is per-process with process ID 0 and register address 0.
- R3: A global access to a known group raises greg_valid for exactly one cycle, the cycle after acceptance, with greg_group = offset[30:8], greg_index = offset[7:0], and greg_write and greg_wdata taken from the request. A read returns the greg_rdata value present in that strobe cycle.
- R4: The known global groups are 0x0, 0x1A0 and 0x1C0. A global access to any other group gives no strobe, and its response has rsp_err = 1 and rsp_rdata = 0.
- R5: A per-process access drives offset[30:22] on axi_awuser or axi_aruser, and offset[21:0] on axi_awaddr or axi_araddr.
- R6: A per-process write raises axi_awvalid and axi_wvalid in the same cycle. It drops each one after its own handshake, drives axi_wdata = req_wdata[31:0] and axi_wstrb = 4'hF, and raises axi_bready only after both handshakes.
- R7: A per-process read returns axi_rdata zero-extended to 64 bits on rsp_rdata. A write response carries rsp_rdata = 0.
- R8: An AXI response code other than OKAY (2'b00) on axi_bresp or axi_rresp gives rsp_err = 1. OKAY gives rsp_err = 0.
- R9: After reset req_ready = 1 and rsp_valid = 0. req_ready is low from acceptance until the response handshake. rsp_valid and its data stay stable until rsp_ready is high.
- R10: axi_awvalid, axi_wvalid and axi_arvalid stay high, with stable address, user and data, until their handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bar_base | input | 32 | Programmed base for address bits 63:32 |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 64 | Request address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 64 | Read data |
| greg_valid | output | 1 | Global register access strobe |
| greg_write | output | 1 | Global access is a write |
| greg_group | output | 23 | Global register group |
| greg_index | output | 8 | Register within the group |
| greg_wdata | output | 64 | Global write data |
| greg_rdata | input | 64 | Global read data, sampled during the strobe |
| axi_awvalid | output | 1 | AXI write address valid |
| axi_awready | input | 1 | AXI write address ready |
| axi_awaddr | output | 22 | AXI write address |
| axi_awuser | output | 9 | Process ID for the write |
| axi_wvalid | output | 1 | AXI write data valid |
| axi_wready | input | 1 | AXI write data ready |
| axi_wdata | output | 32 | AXI write data |
| axi_wstrb | output | 4 | AXI byte strobes |
| axi_bvalid | input | 1 | AXI write response valid |
| axi_bready | output | 1 | AXI write response ready |
| axi_bresp | input | 2 | AXI write response code |
| axi_arvalid | output | 1 | AXI read address valid |
| axi_arready | input | 1 | AXI read address ready |
| axi_araddr | output | 22 | AXI read address |
| axi_aruser | output | 9 | Process ID for the read |
| axi_rvalid | input | 1 | AXI read data valid |
| axi_rready | output | 1 | AXI read data ready |
| axi_rdata | input | 32 | AXI read data |
| axi_rresp | input | 2 | AXI read response code |

## Verification
In a per-process write, the write-address and write-data handshakes can complete in the same cycle, or either one can complete first. The bench's AXI responder adds a chosen number of wait cycles before each ready: zero on both channels, three on the address channel only, and two on the data channel only. For each case it records the cycle of each handshake. It then judges the result by the gap between the two handshakes, by exactly one handshake per channel, by the captured address, user and data values, and by a single clean response to the host.

// File: rtl/mmio_bridge_pkg.sv
package mmio_bridge_pkg;
  // global register groups that have a register port behind them
  localparam int GRP_BASIC = 32'h000;
  localparam int GRP_DEBUG = 32'h1A0;
  localparam int GRP_FAULT = 32'h1C0;

  typedef enum logic [1:0] {
    B_IDLE,
    B_CLASSIFY,
    B_AXI,
    B_RESP
  } bridge_state_t;

  typedef enum logic [2:0] {
    M_IDLE,
    M_WADDR,
    M_WRESP,
    M_RADDR,
    M_RDATA
  } axil_state_t;
endpackage

// File: rtl/mmio_rst_sync.sv
module mmio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_bridge_pkg::*;
#(
  parameter int HALF_W   = 32,
  parameter int PID_W    = 9,
  parameter int PP_OFF_W = 22,
  parameter int IDX_W    = 8,
  localparam int GRP_W   = HALF_W - 1 - IDX_W,
  localparam int ADDR_W  = 2 * HALF_W
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   base,
  output logic                hit,
  output logic                per_proc,
  output logic [PID_W-1:0]    pid,
  output logic [PP_OFF_W-1:0] pp_off,
  output logic [GRP_W-1:0]    grp,
  output logic [IDX_W-1:0]    idx,
  output logic                grp_known
);
  logic [HALF_W-1:0] off;

  assign off      = addr[HALF_W-1:0];
  assign hit      = (addr[ADDR_W-1:HALF_W] == base);
  assign per_proc = off[HALF_W-1];
  assign pid      = off[PP_OFF_W +: PID_W];
  assign pp_off   = off[PP_OFF_W-1:0];
  assign grp      = off[IDX_W +: GRP_W];
  assign idx      = off[IDX_W-1:0];

  assign grp_known = (grp == GRP_W'(GRP_BASIC)) ||
                     (grp == GRP_W'(GRP_DEBUG)) ||
                     (grp == GRP_W'(GRP_FAULT));
endmodule

// File: rtl/mmio_axil_master.sv
module mmio_axil_master
  import mmio_bridge_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 32,
  parameter int UW = 9,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_write,
  input  logic [AW-1:0] addr,
  input  logic [UW-1:0] user,
  input  logic [DW-1:0] wr_data,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          m_awvalid,
  input  logic          m_awready,
  output logic [AW-1:0] m_awaddr,
  output logic [UW-1:0] m_awuser,
  output logic          m_wvalid,
  input  logic          m_wready,
  output logic [DW-1:0] m_wdata,
  output logic [SW-1:0] m_wstrb,
  input  logic          m_bvalid,
  output logic          m_bready,
  input  logic [1:0]    m_bresp,
  output logic          m_arvalid,
  input  logic          m_arready,
  output logic [AW-1:0] m_araddr,
  output logic [UW-1:0] m_aruser,
  input  logic          m_rvalid,
  output logic          m_rready,
  input  logic [DW-1:0] m_rdata,
  input  logic [1:0]    m_rresp
);
  axil_state_t st, st_n;
  logic aw_ok, aw_ok_n, w_ok, w_ok_n;

  assign m_awaddr = addr;
  assign m_araddr = addr;
  assign m_awuser = user;
  assign m_aruser = user;
  assign m_wdata  = wr_data;
  assign m_wstrb  = '1;
  assign rd_data  = m_rdata;
  assign err      = (st == M_WRESP) ? (m_bresp != 2'b00) : (m_rresp != 2'b00);

  always_comb begin
    st_n      = st;
    aw_ok_n   = aw_ok;
    w_ok_n    = w_ok;
    done      = 1'b0;
    m_awvalid = (st == M_WADDR) && !aw_ok;
    m_wvalid  = (st == M_WADDR) && !w_ok;
    m_bready  = (st == M_WRESP);
    m_arvalid = (st == M_RADDR);
    m_rready  = (st == M_RDATA);
    case (st)
      M_IDLE: begin
        aw_ok_n = 1'b0;
        w_ok_n  = 1'b0;
        if (start) st_n = is_write ? M_WADDR : M_RADDR;
      end
      M_WADDR: begin
        if (m_awvalid && m_awready) aw_ok_n = 1'b1;
        if (m_wvalid && m_wready)   w_ok_n  = 1'b1;
        if (aw_ok_n && w_ok_n)      st_n    = M_WRESP;
      end
      M_WRESP: if (m_bvalid) begin
        done = 1'b1;
        st_n = M_IDLE;
      end
      M_RADDR: if (m_arready) st_n = M_RDATA;
      M_RDATA: if (m_rvalid) begin
        done = 1'b1;
        st_n = M_IDLE;
      end
      default: st_n = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= M_IDLE;
      aw_ok <= 1'b0;
      w_ok  <= 1'b0;
    end else begin
      st    <= st_n;
      aw_ok <= aw_ok_n;
      w_ok  <= w_ok_n;
    end
  end
endmodule

// File: rtl/mmio_window_bridge.sv
module mmio_window_bridge
  import mmio_bridge_pkg::*;
#(
  parameter int HALF_W   = 32,
  parameter int GDW      = 64,
  parameter int ADW      = 32,
  parameter int PID_W    = 9,
  parameter int PP_OFF_W = 22,
  parameter int IDX_W    = 8,
  localparam int GRP_W   = HALF_W - 1 - IDX_W,
  localparam int ADDR_W  = 2 * HALF_W,
  localparam int SW      = ADW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   bar_base,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [GDW-1:0]      req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_err,
  output logic [GDW-1:0]      rsp_rdata,
  output logic                greg_valid,
  output logic                greg_write,
  output logic [GRP_W-1:0]    greg_group,
  output logic [IDX_W-1:0]    greg_index,
  output logic [GDW-1:0]      greg_wdata,
  input  logic [GDW-1:0]      greg_rdata,
  output logic                axi_awvalid,
  input  logic                axi_awready,
  output logic [PP_OFF_W-1:0] axi_awaddr,
  output logic [PID_W-1:0]    axi_awuser,
  output logic                axi_wvalid,
  input  logic                axi_wready,
  output logic [ADW-1:0]      axi_wdata,
  output logic [SW-1:0]       axi_wstrb,
  input  logic                axi_bvalid,
  output logic                axi_bready,
  input  logic [1:0]          axi_bresp,
  output logic                axi_arvalid,
  input  logic                axi_arready,
  output logic [PP_OFF_W-1:0] axi_araddr,
  output logic [PID_W-1:0]    axi_aruser,
  input  logic                axi_rvalid,
  output logic                axi_rready,
  input  logic [ADW-1:0]      axi_rdata,
  input  logic [1:0]          axi_rresp
);
  bridge_state_t st, st_n;
  logic rst_sync_n;

  logic              r_write;
  logic [ADDR_W-1:0] r_addr;
  logic [GDW-1:0]    r_wdata;
  logic              q_err;
  logic [GDW-1:0]    q_data;

  logic                hit, per_proc, grp_known;
  logic [PID_W-1:0]    pid;
  logic [PP_OFF_W-1:0] pp_off;

  logic           load_req, axi_start, cap_en, cap_err;
  logic [GDW-1:0] cap_data;
  logic           m_done, m_err;
  logic [ADW-1:0] m_rdata;

  mmio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mmio_addr_decode #(
    .HALF_W(HALF_W), .PID_W(PID_W), .PP_OFF_W(PP_OFF_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr(r_addr), .base(bar_base), .hit(hit), .per_proc(per_proc),
    .pid(pid), .pp_off(pp_off), .grp(greg_group), .idx(greg_index),
    .grp_known(grp_known)
  );

  mmio_axil_master #(.AW(PP_OFF_W), .DW(ADW), .UW(PID_W)) u_axi (
    .clk(clk), .rst_n(rst_sync_n), .start(axi_start), .is_write(r_write),
    .addr(pp_off), .user(pid), .wr_data(r_wdata[ADW-1:0]),
    .done(m_done), .err(m_err), .rd_data(m_rdata),
    .m_awvalid(axi_awvalid), .m_awready(axi_awready), .m_awaddr(axi_awaddr),
    .m_awuser(axi_awuser), .m_wvalid(axi_wvalid), .m_wready(axi_wready),
    .m_wdata(axi_wdata), .m_wstrb(axi_wstrb), .m_bvalid(axi_bvalid),
    .m_bready(axi_bready), .m_bresp(axi_bresp), .m_arvalid(axi_arvalid),
    .m_arready(axi_arready), .m_araddr(axi_araddr), .m_aruser(axi_aruser),
    .m_rvalid(axi_rvalid), .m_rready(axi_rready), .m_rdata(axi_rdata),
    .m_rresp(axi_rresp)
  );

  assign req_ready  = (st == B_IDLE);
  assign rsp_valid  = (st == B_RESP);
  assign rsp_err    = q_err;
  assign rsp_rdata  = q_data;
  assign greg_write = r_write;
  assign greg_wdata = r_wdata;

  always_comb begin
    st_n       = st;
    load_req   = 1'b0;
    axi_start  = 1'b0;
    greg_valid = 1'b0;
    cap_en     = 1'b0;
    cap_err    = 1'b0;
    cap_data   = '0;
    case (st)
      B_IDLE: if (req_valid) begin
        load_req = 1'b1;
        st_n     = B_CLASSIFY;
      end
      B_CLASSIFY: begin
        if (!hit) begin
          st_n = B_IDLE;
        end else if (per_proc) begin
          axi_start = 1'b1;
          st_n      = B_AXI;
        end else begin
          greg_valid = grp_known;
          cap_en     = 1'b1;
          cap_err    = !grp_known;
          cap_data   = (grp_known && !r_write) ? greg_rdata : '0;
          st_n       = B_RESP;
        end
      end
      B_AXI: if (m_done) begin
        cap_en   = 1'b1;
        cap_err  = m_err;
        cap_data = r_write ? '0 : {{(GDW-ADW){1'b0}}, m_rdata};
        st_n     = B_RESP;
      end
      B_RESP: if (rsp_ready) st_n = B_IDLE;
      default: st_n = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st <= B_IDLE;
    else             st <= st_n;
  end

  always_ff @(posedge clk) begin
    if (load_req) begin
      r_write <= req_write;
      r_addr  <= req_addr;
      r_wdata <= req_wdata;
    end
    if (cap_en) begin
      q_err  <= cap_err;
      q_data <= cap_data;
    end
  end
endmodule

// File: rtl/mmio_window_bridge_chk.sv
module mmio_window_bridge_chk #(
  parameter int GDW      = 64,
  parameter int ADW      = 32,
  parameter int PID_W    = 9,
  parameter int PP_OFF_W = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_err,
  input logic [GDW-1:0]      rsp_rdata,
  input logic                greg_valid,
  input logic                axi_awvalid,
  input logic                axi_awready,
  input logic [PP_OFF_W-1:0] axi_awaddr,
  input logic [PID_W-1:0]    axi_awuser,
  input logic                axi_wvalid,
  input logic                axi_wready,
  input logic [ADW-1:0]      axi_wdata,
  input logic                axi_bready,
  input logic                axi_arvalid,
  input logic                axi_arready,
  input logic [PP_OFF_W-1:0] axi_araddr,
  input logic [PID_W-1:0]    axi_aruser
);
  assert_ready_vs_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  assert_aw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    axi_awvalid && !axi_awready |=> axi_awvalid && $stable(axi_awaddr) && $stable(axi_awuser));

  assert_w_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    axi_wvalid && !axi_wready |=> axi_wvalid && $stable(axi_wdata));

  assert_ar_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    axi_arvalid && !axi_arready |=> axi_arvalid && $stable(axi_araddr) && $stable(axi_aruser));

  assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    greg_valid |=> !greg_valid);

  assert_no_mix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(greg_valid && (axi_awvalid || axi_wvalid || axi_arvalid)));

  assert_bready_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    axi_bready |-> !axi_awvalid && !axi_wvalid);
endmodule

bind mmio_window_bridge mmio_window_bridge_chk #(
  .GDW(GDW), .ADW(ADW), .PID_W(PID_W), .PP_OFF_W(PP_OFF_W)
) chk (.*);

// File: tb/mmio_window_bridge_test.sv
`timescale 1ns/1ps
module mmio_window_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bar_base;
  logic        req_valid, req_ready, req_write;
  logic [63:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [63:0] rsp_rdata;
  logic        greg_valid, greg_write;
  logic [22:0] greg_group;
  logic [7:0]  greg_index;
  logic [63:0] greg_wdata, greg_rdata;
  logic        axi_awvalid, axi_awready, axi_wvalid, axi_wready;
  logic [21:0] axi_awaddr, axi_araddr;
  logic [8:0]  axi_awuser, axi_aruser;
  logic [31:0] axi_wdata, axi_rdata;
  logic [3:0]  axi_wstrb;
  logic        axi_bvalid, axi_bready, axi_arvalid, axi_arready, axi_rvalid, axi_rready;
  logic [1:0]  axi_bresp, axi_rresp;

  always #10 clk = ~clk;

  assign greg_rdata = {9'h0, greg_group, 24'hA5A5A5, greg_index};

  mmio_window_bridge uut (.*);

  int n_checks = 0, n_err = 0, cyc = 0;
  bit finished = 0;
  int aw_lat = 0, w_lat = 0;
  logic [1:0]  b_resp_cfg = 2'b00, r_resp_cfg = 2'b00;
  logic [31:0] r_data_cfg = 32'h0;

  int aw_hs = 0, w_hs = 0, ar_hs = 0, g_cnt = 0, aw_t = 0, w_t = 0;
  logic [21:0] s_awaddr, s_araddr;
  logic [8:0]  s_awuser, s_aruser;
  logic [31:0] s_wdata;
  logic [3:0]  s_wstrb;
  logic        g_write;
  logic [22:0] g_group;
  logic [7:0]  g_index;
  logic [63:0] g_wdata;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // AXI4-Lite responder and strobe monitor, stepping on falling edges
  initial begin
    bit aw_fire = 0, w_fire = 0, b_fire = 0, ar_fire = 0, r_fire = 0;
    bit aw_got = 0, w_got = 0, r_pend = 0;
    int aw_cnt = 0, w_cnt = 0;
    axi_awready = 0; axi_wready = 0; axi_bvalid = 0; axi_bresp = 0;
    axi_arready = 0; axi_rvalid = 0; axi_rdata = 0; axi_rresp = 0;
    forever begin
      @(negedge clk);
      if (greg_valid) begin
        g_cnt++; g_write = greg_write; g_group = greg_group;
        g_index = greg_index; g_wdata = greg_wdata;
      end
      if (aw_fire) begin axi_awready = 0; aw_fire = 0; end
      if (w_fire)  begin axi_wready = 0;  w_fire = 0;  end
      if (b_fire)  begin axi_bvalid = 0;  b_fire = 0;  end
      if (ar_fire) begin axi_arready = 0; ar_fire = 0; r_pend = 1; end
      if (r_fire)  begin axi_rvalid = 0;  r_fire = 0;  end
      if (axi_awvalid && !axi_awready) begin
        if (aw_cnt >= aw_lat) begin axi_awready = 1; aw_cnt = 0; end else aw_cnt++;
      end
      if (axi_wvalid && !axi_wready) begin
        if (w_cnt >= w_lat) begin axi_wready = 1; w_cnt = 0; end else w_cnt++;
      end
      if (axi_arvalid && !axi_arready) axi_arready = 1;
      if (aw_got && w_got && !axi_bvalid) begin
        axi_bvalid = 1; axi_bresp = b_resp_cfg; aw_got = 0; w_got = 0;
      end
      if (r_pend && !axi_rvalid) begin
        axi_rvalid = 1; axi_rdata = r_data_cfg; axi_rresp = r_resp_cfg; r_pend = 0;
      end
      aw_fire = axi_awvalid && axi_awready;
      if (aw_fire) begin aw_got = 1; aw_hs++; aw_t = cyc; s_awaddr = axi_awaddr; s_awuser = axi_awuser; end
      w_fire = axi_wvalid && axi_wready;
      if (w_fire) begin w_got = 1; w_hs++; w_t = cyc; s_wdata = axi_wdata; s_wstrb = axi_wstrb; end
      b_fire = axi_bvalid && axi_bready;
      ar_fire = axi_arvalid && axi_arready;
      if (ar_fire) begin ar_hs++; s_araddr = axi_araddr; s_aruser = axi_aruser; end
      r_fire = axi_rvalid && axi_rready;
    end
  end

  task automatic host_access(input logic wr, input logic [63:0] a, input logic [63:0] d,
                             input int hold, output logic got, output logic err,
                             output logic [63:0] rd);
    int n;
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
    got = rsp_valid; err = rsp_err; rd = rsp_rdata;
    if (got) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(rsp_valid && !req_ready && rsp_rdata === rd, "R9 response held", rsp_rdata, rd);
      end
      rsp_ready = 1;
      @(negedge clk);
      rsp_ready = 0;
    end
  endtask

  localparam logic [31:0] BASE = 32'h0000_0004;

  task automatic t_reset;
    chk_eq("R9 reset req_ready", req_ready, 1);
    chk_eq("R9 reset rsp_valid", rsp_valid, 0);
    chk_eq("R9 reset axi valids", {axi_awvalid, axi_wvalid, axi_arvalid, greg_valid}, 0);
  endtask

  task automatic t_unmatched;
    logic got, err; logic [63:0] rd; int g0, a0, r0;
    g0 = g_cnt; a0 = aw_hs + w_hs; r0 = ar_hs;
    host_access(1, {32'h0000_0005, 32'h0000_0010}, 64'h1, 0, got, err, rd);
    chk_eq("R1 no response", got, 0);
    chk_eq("R1 no strobe", g_cnt - g0, 0);
    chk_eq("R1 no AXI write", aw_hs + w_hs - a0, 0);
    host_access(0, {32'h0000_0006, 32'h8000_0000}, 64'h0, 0, got, err, rd);
    chk_eq("R1 no response pp", got, 0);
    chk_eq("R1 no AXI read", ar_hs - r0, 0);
    chk_eq("R1 ready again", req_ready, 1);
  endtask

  task automatic t_glb_write;
    logic got, err; logic [63:0] rd; int g0, a0;
    g0 = g_cnt; a0 = aw_hs;
    host_access(1, {BASE, 32'h0000_0010}, 64'h1122_3344_5566_7788, 0, got, err, rd);
    chk_eq("R3 one strobe", g_cnt - g0, 1);
    chk_eq("R3 group", g_group, 0);
    chk_eq("R3 index", g_index, 8'h10);
    chk_eq("R3 write flag", g_write, 1);
    chk_eq("R3 wdata", g_wdata, 64'h1122_3344_5566_7788);
    chk_eq("R2 global no AXI", aw_hs - a0, 0);
    chk_eq("R3 ok response", {got, err}, 2'b10);
  endtask

  task automatic t_glb_read(input logic [31:0] off, input logic [22:0] grp, input logic [7:0] idx);
    logic got, err; logic [63:0] rd; int g0;
    g0 = g_cnt;
    host_access(0, {BASE, off}, 64'h0, 0, got, err, rd);
    chk_eq("R4 known group strobe", g_cnt - g0, 1);
    chk_eq("R3 read data", rd, {9'h0, grp, 24'hA5A5A5, idx});
    chk_eq("R3 read no error", {got, err}, 2'b10);
  endtask

  task automatic t_glb_unmapped(input logic [31:0] off);
    logic got, err; logic [63:0] rd; int g0, r0;
    g0 = g_cnt; r0 = ar_hs;
    host_access(0, {BASE, off}, 64'h0, 0, got, err, rd);
    chk_eq("R4 unmapped no strobe", g_cnt - g0, 0);
    chk_eq("R4 unmapped error", {got, err}, 2'b11);
    chk_eq("R4 unmapped zero data", rd, 0);
    chk_eq("R2 global edge no AXI", ar_hs - r0, 0);
  endtask

  task automatic t_pp_write(input int lat_a, input int lat_w, input logic [1:0] bresp);
    logic got, err; logic [63:0] rd; int a0, w0;
    aw_lat = lat_a; w_lat = lat_w; b_resp_cfg = bresp;
    a0 = aw_hs; w0 = w_hs;
    host_access(1, {BASE, 32'hFFFA_BCD4}, 64'hDEAD_BEEF_CAFE_F00D, 0, got, err, rd);
    chk_eq("R6 one AW and one W", {aw_hs - a0, w_hs - w0}, {32'd1, 32'd1});
    chk_eq("R6 handshake gap", w_t - aw_t, lat_w - lat_a);
    chk_eq("R5 awaddr", s_awaddr, 22'h3A_BCD4);
    chk_eq("R5 awuser", s_awuser, 9'h1FF);
    chk_eq("R6 wdata low half", s_wdata, 32'hCAFE_F00D);
    chk_eq("R6 wstrb", s_wstrb, 4'hF);
    chk_eq("R8 write err", {got, err}, {1'b1, bresp != 2'b00});
    chk_eq("R7 write data zero", rd, 0);
    aw_lat = 0; w_lat = 0; b_resp_cfg = 0;
  endtask

  task automatic t_pp_read(input logic [31:0] off, input logic [21:0] ea, input logic [8:0] eu,
                           input logic [31:0] data, input logic [1:0] rresp);
    logic got, err; logic [63:0] rd; int r0;
    r_data_cfg = data; r_resp_cfg = rresp; r0 = ar_hs;
    host_access(0, {BASE, off}, 64'h0, 0, got, err, rd);
    chk_eq("R2 per-process read issued", ar_hs - r0, 1);
    chk_eq("R5 araddr", s_araddr, ea);
    chk_eq("R5 aruser", s_aruser, eu);
    chk_eq("R7 read data", rd, {32'h0, data});
    chk_eq("R8 read err", {got, err}, {1'b1, rresp != 2'b00});
    r_resp_cfg = 0;
  endtask

  task automatic t_hold;
    logic got, err; logic [63:0] rd;
    host_access(0, {BASE, 32'h0001_C000}, 64'h0, 4, got, err, rd);
    chk_eq("R9 held response data", rd, {9'h0, 23'h1C0, 24'hA5A5A5, 8'h00});
    @(negedge clk);
    chk_eq("R9 ready after response", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; bar_base = BASE; req_valid = 0; req_write = 0;
    req_addr = 0; req_wdata = 0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_unmatched();
    t_glb_write();
    t_glb_read(32'h0001_A028, 23'h1A0, 8'h28);
    t_glb_read(32'h0001_C008, 23'h1C0, 8'h08);
    t_glb_unmapped(32'h0000_0508);
    t_glb_unmapped(32'h7FFF_FFF8);
    t_pp_read(32'h8000_0000, 22'h0, 9'h0, 32'h0BAD_F00D, 2'b00);
    t_pp_write(0, 0, 2'b00);
    t_pp_write(3, 0, 2'b00);
    t_pp_write(0, 2, 2'b00);
    t_pp_read(32'h8140_0010, 22'h10, 9'h5, 32'h5A17_3C09, 2'b00);
    t_pp_read(32'h8140_0014, 22'h14, 9'h5, 32'h1234_5678, 2'b10);
    t_pp_write(1, 1, 2'b11);
    t_hold();
    finish_run();
  end
endmodule